// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block watches three 8-bit groups of general-purpose input pins and turns chosen pin conditions into interrupt requests. Each line has two configuration bits. The first picks level or edge sensitivity. The second picks the active sense: low or falling, or high or rising. Every pin passes through a two-flop synchroniser before any detection. An edge event is held in a per-line latch until software clears it with a write-one-to-clear acknowledge. A level request follows the synchronised pin and is never held.

The three groups are called A, B and F. Each group has a mode register, a sense register, an acknowledge register, an enable register and a masked status register. A line whose enable bit is 0 does not latch events and does not show in status. The status bits of groups A and B are combined into one interrupt output. Each of the eight group F lines drives its own output.

Software may change the mode and sense registers at any time. The safe sequence is to clear the enable register first and restore it afterwards. To get interrupts on both edges, software flips the sense bit after each event. Changing the sense bit never creates an event by itself.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Mode bit 0 makes a line level sensitive. Mode bit 1 makes it edge sensitive.
- R2: Sense bit 1 selects high level or rising edge. Sense bit 0 selects low level or falling edge.
- R3: A pin change reaches status through two synchronising flops. A level request shows after the 2nd rising clock edge that follows the change. An edge event is latched on the 3rd.
- R4: A latched edge event stays set after the pin returns to its idle value. Writing 1 to its bit in the acknowledge register clears it. Writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the new edge wins.
- R5: An acknowledge write has no effect on a level-mode request.
- R6: A line whose enable bit is 0 shows 0 in status, drives no output and latches no edge. An edge that occurs while the line is disabled is not reported after the line is enabled.
- R7: Changing the sense bit of an enabled edge-mode line while its pin is steady creates no event.
- R8: Output irq_ab is the OR of all status bits of groups A and B. Bit i of irq_f equals status bit i of group F.
- R9: Register bases are 0x90 for A, 0xAC for B and 0x4C for F. From each base, the offsets are +0 mode, +4 sense, +8 acknowledge, +0xC enable and +0x10 status. The mode, sense and enable registers read back what was written. Reads of the acknowledge register and of unmapped addresses return 0.
- R10: After reset, all configuration registers are 0, all status bits are 0 and every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 8 | Group A pins, asynchronous |
| pin_b | input | 8 | Group B pins, asynchronous |
| pin_f | input | 8 | Group F pins, asynchronous |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_ab | output | 1 | Combined request of groups A and B |
| irq_f | output | 8 | Per-line requests of group F |

## Verification
The assertions assume three things about the inputs:
- Each write lasts exactly one cycle of bus_we.
- An acknowledge write and a write to the same group's mode or enable register do not happen in the same cycle.
- Pins may change at any time, so the edge checks look only at the synchronised samples and never at the raw pins.

The bench keeps within these assumptions. It changes pins and bus signals only on falling clock edges and issues one register write per task call. It always disables a line before changing its mode or sense. The one exception is the sense-flip case, which is made while the pin is held steady.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NPORT    = 3;
  localparam int OFS_MODE = 0;
  localparam int OFS_SNS  = 4;
  localparam int OFS_ACK  = 8;
  localparam int OFS_EN   = 12;
  localparam int OFS_STAT = 16;

  typedef struct packed {
    logic mode;
    logic sns;
    logic ack;
    logic en;
  } reg_wr_t;

  function automatic logic [7:0] group_base(input int idx);
    case (idx)
      0:       return 8'h90;
      1:       return 8'hAC;
      default: return 8'h4C;
    endcase
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] smp_o,
  output logic [W-1:0] old_o
);
  logic [W-1:0] st1_q, st2_q, st3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
      st3_q <= '0;
    end else begin
      st1_q <= pin_i;
      st2_q <= st1_q;
      st3_q <= st2_q;
    end
  end

  assign smp_o = st2_q;
  assign old_o = st3_q;
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  reg_wr_t      wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mode_o,
  output logic [W-1:0] sns_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] smp, old;
  logic [W-1:0] mode_q, mode_d, sns_q, sns_d, en_q, en_d;
  logic [W-1:0] hold_q, hold_d, evt, clr;

  gpio_irq_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .smp_o(smp), .old_o(old)
  );

  always_comb begin
    mode_d = wr_i.mode ? wdata_i : mode_q;
    sns_d  = wr_i.sns  ? wdata_i : sns_q;
    en_d   = wr_i.en   ? wdata_i : en_q;
    clr    = wr_i.ack  ? wdata_i : '0;
    for (int i = 0; i < W; i++) begin
      evt[i] = mode_q[i] & (sns_q[i] ? (smp[i] & ~old[i]) : (~smp[i] & old[i]));
    end
    hold_d = en_q & mode_q & (evt | (hold_q & ~clr));
    for (int i = 0; i < W; i++) begin
      stat_o[i] = en_q[i] & (mode_q[i] ? hold_q[i] : ~(smp[i] ^ sns_q[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sns_q  <= '0;
      en_q   <= '0;
      hold_q <= '0;
    end else begin
      mode_q <= mode_d;
      sns_q  <= sns_d;
      en_q   <= en_d;
      hold_q <= hold_d;
    end
  end

  assign mode_o = mode_q;
  assign sns_o  = sns_q;
  assign en_o   = en_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    // Keep an edge latch set until a one is written to its acknowledge bit.
    assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q[i] && en_q[i] && mode_q[i] && !wr_i.en && !wr_i.mode &&
       !(wr_i.ack && wdata_i[i])) |=> hold_q[i]);
    // An acknowledge with no new edge in the same cycle clears the latch.
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i.ack && wdata_i[i] && !(smp[i] ^ old[i])) |=> !hold_q[i]);
    // A line that is disabled latches nothing in the next cycle.
    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |=> !hold_q[i]);
    // With a steady pin, no event appears, whatever the sense bit does.
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_q[i] && smp[i] == old[i]) |=> !hold_q[i]);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pin_a,
  input  logic [W-1:0]  pin_b,
  input  logic [W-1:0]  pin_f,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_we,
  output logic [W-1:0]  bus_rdata,
  output logic          irq_ab,
  output logic [W-1:0]  irq_f
);
  logic [W-1:0] pins [NPORT];
  logic [W-1:0] mode [NPORT];
  logic [W-1:0] sns  [NPORT];
  logic [W-1:0] en   [NPORT];
  logic [W-1:0] stat [NPORT];

  assign pins[0] = pin_a;
  assign pins[1] = pin_b;
  assign pins[2] = pin_f;

  for (genvar p = 0; p < NPORT; p++) begin : g_grp
    localparam logic [AW-1:0] BASE = AW'(group_base(p));
    reg_wr_t wr;
    always_comb begin
      wr.mode = bus_we && (bus_addr == BASE + AW'(OFS_MODE));
      wr.sns  = bus_we && (bus_addr == BASE + AW'(OFS_SNS));
      wr.ack  = bus_we && (bus_addr == BASE + AW'(OFS_ACK));
      wr.en   = bus_we && (bus_addr == BASE + AW'(OFS_EN));
    end
    gpio_irq_group #(.W(W)) u_grp (
      .clk(clk), .rst_n(rst_n), .pin_i(pins[p]), .wr_i(wr), .wdata_i(bus_wdata),
      .mode_o(mode[p]), .sns_o(sns[p]), .en_o(en[p]), .stat_o(stat[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (bus_addr == AW'(group_base(p)) + AW'(OFS_MODE)) bus_rdata = mode[p];
      if (bus_addr == AW'(group_base(p)) + AW'(OFS_SNS))  bus_rdata = sns[p];
      if (bus_addr == AW'(group_base(p)) + AW'(OFS_EN))   bus_rdata = en[p];
      if (bus_addr == AW'(group_base(p)) + AW'(OFS_STAT)) bus_rdata = stat[p];
    end
  end

  assign irq_ab = |(stat[0] | stat[1]);
  assign irq_f  = stat[2];
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pa = '0, pb = '0, pf = '0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic we = 1'b0;
  logic irq_ab;
  logic [7:0] irq_f;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_a(pa), .pin_b(pb), .pin_f(pf),
    .bus_addr(addr), .bus_wdata(wdata), .bus_we(we), .bus_rdata(rdata),
    .irq_ab(irq_ab), .irq_f(irq_f)
  );

  typedef struct packed {
    logic [1:0] grp;
    logic [2:0] line;
    logic       mode;
    logic       sns;
    logic       p0;
    logic       p1;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{2'd0, 3'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{2'd1, 3'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{2'd1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd2, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{2'd2, 3'd6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{2'd0, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{2'd1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd2, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{2'd1, 3'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  function automatic logic [7:0] base(input int g);
    return (g == 0) ? 8'h90 : (g == 1) ? 8'hAC : 8'h4C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(tag, {24'd0, rdata}, {24'd0, exp});
  endtask

  task automatic set_pin(input int g, input int ln, input logic v);
    case (g)
      0: pa[ln] = v;
      1: pb[ln] = v;
      default: pf[ln] = v;
    endcase
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet_all();
    for (int g = 0; g < 3; g++) wr(base(g) + 8'h0C, 8'h00);
    @(negedge clk);
    pa = '0; pb = '0; pf = '0;
    settle();
    for (int g = 0; g < 3; g++) begin
      wr(base(g) + 8'h00, 8'h00);
      wr(base(g) + 8'h04, 8'h00);
      wr(base(g) + 8'h08, 8'hFF);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    for (int g = 0; g < 3; g++) begin
      rd_chk("R10 mode reset", base(g), 8'h00);
      rd_chk("R10 sense reset", base(g) + 8'h04, 8'h00);
      rd_chk("R10 enable reset", base(g) + 8'h0C, 8'h00);
      rd_chk("R10 status reset", base(g) + 8'h10, 8'h00);
    end
    chk("R10 irq_ab reset", {31'd0, irq_ab}, 32'd0);
    chk("R10 irq_f reset", {24'd0, irq_f}, 32'd0);

    // Table: R1 R2 R8 under several modes, senses and groups
    for (int k = 0; k < 10; k++) begin
      vec_t v = VEC[k];
      logic [7:0] m;
      m = 8'h01 << v.line;
      quiet_all();
      @(negedge clk);
      set_pin(int'(v.grp), int'(v.line), v.p0);
      wr(base(v.grp) + 8'h00, v.mode ? m : 8'h00);
      wr(base(v.grp) + 8'h04, v.sns ? m : 8'h00);
      settle();
      wr(base(v.grp) + 8'h0C, m);
      wr(base(v.grp) + 8'h08, m);
      set_pin(int'(v.grp), int'(v.line), v.p1);
      settle();
      rd_chk("R1 R2 table status", base(v.grp) + 8'h10, v.exp ? m : 8'h00);
      if (v.grp == 2'd2) chk("R8 table irq_f", {24'd0, irq_f}, {24'd0, v.exp ? m : 8'h00});
      else               chk("R8 table irq_ab", {31'd0, irq_ab}, {31'd0, v.exp});
    end

    // R3: latency through the synchroniser, edge path
    quiet_all();
    wr(8'h90, 8'h04); wr(8'h94, 8'h04); wr(8'h9C, 8'h04);
    @(negedge clk); pa[2] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    rd_chk("R3 edge not yet latched", 8'hA0, 8'h00);
    @(posedge clk); @(negedge clk);
    rd_chk("R3 edge latched on 3rd edge", 8'hA0, 8'h04);
    // R4: held after pin returns, ack with 0 keeps, ack with 1 clears
    pa[2] = 1'b0;
    settle();
    rd_chk("R4 latch holds", 8'hA0, 8'h04);
    wr(8'h98, 8'hFB);
    rd_chk("R4 zero ack keeps", 8'hA0, 8'h04);
    wr(8'h98, 8'h04);
    rd_chk("R4 one ack clears", 8'hA0, 8'h00);

    // R3: latency, level path
    wr(8'hB0, 8'h02); wr(8'hB8, 8'h02);
    @(negedge clk); pb[1] = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_chk("R3 level after 1 edge", 8'hBC, 8'h00);
    @(posedge clk); @(negedge clk);
    rd_chk("R3 level after 2 edges", 8'hBC, 8'h02);
    // R5: ack does not affect level request
    wr(8'hB4, 8'hFF);
    rd_chk("R5 level survives ack", 8'hBC, 8'h02);
    chk("R5 irq_ab stays", {31'd0, irq_ab}, 32'd1);
    // R6: disable hides a level request
    wr(8'hB8, 8'h00);
    rd_chk("R6 disabled level hidden", 8'hBC, 8'h00);
    chk("R6 irq_ab low when disabled", {31'd0, irq_ab}, 32'd0);

    // R6: edge while disabled is not reported later
    quiet_all();
    wr(8'h90, 8'h08); wr(8'h94, 8'h08);
    @(negedge clk); pa[3] = 1'b1;
    settle();
    wr(8'h9C, 8'h08);
    settle();
    rd_chk("R6 edge while disabled dropped", 8'hA0, 8'h00);

    // R7: sense flip with steady pin makes no event; then falling edge works
    quiet_all();
    wr(8'h4C, 8'h20); wr(8'h50, 8'h20); wr(8'h58, 8'h20);
    @(negedge clk); pf[5] = 1'b1;
    settle();
    chk("R8 irq_f line5", {24'd0, irq_f}, 32'h20);
    wr(8'h54, 8'h20);
    wr(8'h50, 8'h00);
    settle();
    rd_chk("R7 sense flip no event", 8'h5C, 8'h00);
    pf[5] = 1'b0;
    settle();
    rd_chk("R7 falling after flip", 8'h5C, 8'h20);
    chk("R8 only line5 on irq_f", {24'd0, irq_f}, 32'h20);
    chk("R8 F does not reach irq_ab", {31'd0, irq_ab}, 32'd0);

    // R9: readback and map
    wr(8'hAC, 8'h5A); wr(8'hB0, 8'hC3); wr(8'h58, 8'h81);
    rd_chk("R9 B mode readback", 8'hAC, 8'h5A);
    rd_chk("R9 B sense readback", 8'hB0, 8'hC3);
    rd_chk("R9 F enable readback", 8'h58, 8'h81);
    rd_chk("R9 A mode untouched", 8'h90, 8'h00);
    rd_chk("R9 ack reads zero", 8'hB4, 8'h00);
    rd_chk("R9 unmapped reads zero", 8'h00, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule